// File: doc/BRIEF.md
# Chained Scatter-Gather List Walker

This block sits beside a DMA channel and turns a chained scatter-gather list in memory into a stream of segment descriptors. A one-cycle start pulse gives it the address of the first table and the number of bytes the transfer needs. It then reads the list one 64-bit entry at a time over a simple request/response read port. Only one read is outstanding at any time.

Each ordinary entry becomes one descriptor (36-bit address, 16-bit byte length) on a valid/ready output. A continuation entry sends the walk to another table and produces no descriptor. The walk ends at the first ordinary entry that carries the closing flag. At that point the block checks that the lengths it has seen add up exactly to the requested byte count. The result is given on a status output: a done level, an error flag, and a 2-bit error code. All three stay as they are until the next start. The channel then goes on with its own next descriptor.

Top module: `sgWalker`

## Requirements
- R1: After an accepted start, the first read is issued at `startAddr`. Within a table, each further read is 8 bytes above the previous one. No read is issued while a descriptor is waiting at the output.
- R2: An entry is decoded as follows. Bits [63:48] hold the length. Bit 41 is the closing flag. Bit 40 is the continuation flag. Bits [35:32] hold the pointer extension. Bits [31:0] hold the pointer. An entry with bit 40 clear emits exactly one descriptor, whose length is bits [63:48] and whose low 32 address bits are bits [31:0].
- R3: When `extEn` is 1, address bits [35:32] of both descriptors and next-table reads come from entry bits [35:32]. When `extEn` is 0, those address bits are zero.
- R4: An entry with bit 40 set and a zero length emits no descriptor. The next read goes to the address that entry holds. Its closing flag has no effect.
- R5: An entry with bit 40 set and a non-zero length stops the walk with error code 3. No descriptor is emitted for it.
- R6: An entry with bit 40 clear and a zero length stops the walk with error code 1. No descriptor is emitted for it.
- R7: If the running byte total equals the requested count at the entry that carries the closing flag, that entry's descriptor is emitted. After it is accepted, `done` goes to 1 with `errFlag` 0 and code 0.
- R8: The walk stops with error code 2, and the offending entry is not emitted, in two cases: the running total exceeds the requested count at any entry, or it differs from the count at the closing entry.
- R9: After an error, `done` and `errFlag` are 1 and the code is held. No further read is issued until the next start.
- R10: A descriptor holds `segValid`, `segAddr` and `segLen` steady until `segReady`. Every descriptor is delivered exactly once.
- R11: A read request holds `memReqValid` and `memReqAddr` steady until `memReqReady`. Each entry is read exactly once.
- R12: A start pulse while `busy` is 1 is ignored.
- R13: After reset, `busy`, `done`, `errFlag`, `memReqValid` and `segValid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a walk (accepted when not busy) |
| startAddr | input | 36 | Address of the first table |
| startTotal | input | TOTAL_W | Byte count the list must add up to |
| extEn | input | 1 | Use entry bits [35:32] as upper address bits |
| memReqValid | output | 1 | Entry read request |
| memReqReady | input | 1 | Read request accepted |
| memReqAddr | output | 36 | Address of the entry to read |
| memRspValid | input | 1 | Read data valid |
| memRspData | input | 64 | Entry read back |
| segValid | output | 1 | Descriptor valid |
| segReady | input | 1 | Descriptor accepted |
| segAddr | output | 36 | Descriptor address |
| segLen | output | 16 | Descriptor length in bytes |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Walk finished (held until next start) |
| errFlag | output | 1 | Walk finished with an error |
| errCode | output | 2 | 0 none, 1 zero length, 2 count mismatch, 3 continuation with length |

## Verification
The closing flag and the byte-count comparison are both judged on the same entry. The sweep sets the requested count to the exact list sum, one above it, one below it, and one below the sum that excludes the final entry. This makes the closing entry land on an exact match, on a short total, or on an overshoot. In the last case the overshoot comes one entry earlier. In every case the bench's own walk of the list predicts which entry is the last one read, how many descriptors come out, and which error code results. Continuation entries carry a set closing flag throughout, to show that the closing flag is not acted on there.

// File: rtl/sgPkg.sv
package sgPkg;
  localparam int PTR_W       = 32;
  localparam int EXT_W       = 4;
  localparam int ADDR_W      = PTR_W + EXT_W;
  localparam int LEN_W       = 16;
  localparam int ENTRY_W     = 64;
  localparam int ENTRY_BYTES = ENTRY_W / 8;
  localparam int LAST_BIT    = 41;
  localparam int NEXT_BIT    = 40;

  typedef enum logic [1:0] {
    ERR_NONE     = 2'd0,
    ERR_ZEROLEN  = 2'd1,
    ERR_MISMATCH = 2'd2,
    ERR_NEXTLEN  = 2'd3
  } errCode_t;

  typedef struct packed {
    logic     loadStart;
    logic     jumpTable;
    logic     stepEntry;
    logic     takeSeg;
    logic     setErr;
    errCode_t errVal;
  } dpCtl_t;

  typedef struct packed {
    logic isNext;
    logic lenZero;
    logic overRun;
    logic exactSum;
    logic isLast;
    logic segLast;
  } dpFlags_t;
endpackage

// File: rtl/sgDatapath.sv
module sgDatapath
  import sgPkg::*;
#(
  parameter int TOTAL_W = 20
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpCtl_t              ctl,
  input  logic [ADDR_W-1:0]   startAddr,
  input  logic [TOTAL_W-1:0]  startTotal,
  input  logic                extEn,
  input  logic [ENTRY_W-1:0]  rspData,
  output logic [ADDR_W-1:0]   fetchAddr,
  output logic [ADDR_W-1:0]   segAddr,
  output logic [LEN_W-1:0]    segLen,
  output errCode_t            errCode,
  output dpFlags_t            flags
);
  localparam int SUM_W = TOTAL_W + 1;

  logic [LEN_W-1:0]   fLen;
  logic [EXT_W-1:0]   fExt;
  logic [PTR_W-1:0]   fPtr;
  logic               fLast;
  logic               fNext;
  logic [ADDR_W-1:0]  entryAddr;
  logic [SUM_W-1:0]   sumR;
  logic [SUM_W-1:0]   newSum;
  logic [TOTAL_W-1:0] totalR;
  logic               segLastR;

  // field split of the entry just read
  assign fLen  = rspData[ENTRY_W-1 -: LEN_W];
  assign fLast = rspData[LAST_BIT];
  assign fNext = rspData[NEXT_BIT];
  assign fExt  = rspData[PTR_W +: EXT_W];
  assign fPtr  = rspData[PTR_W-1:0];

  assign entryAddr = {(extEn ? fExt : {EXT_W{1'b0}}), fPtr};
  assign newSum    = sumR + SUM_W'(fLen);

  assign flags.isNext   = fNext;
  assign flags.lenZero  = (fLen == '0);
  assign flags.overRun  = (newSum > SUM_W'(totalR));
  assign flags.exactSum = (newSum == SUM_W'(totalR));
  assign flags.isLast   = fLast;
  assign flags.segLast  = segLastR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fetchAddr <= '0;
      sumR      <= '0;
      totalR    <= '0;
      segAddr   <= '0;
      segLen    <= '0;
      segLastR  <= 1'b0;
      errCode   <= ERR_NONE;
    end else begin
      if (ctl.loadStart) begin
        fetchAddr <= startAddr;
        sumR      <= '0;
        totalR    <= startTotal;
        segLastR  <= 1'b0;
        errCode   <= ERR_NONE;
      end
      if (ctl.jumpTable) fetchAddr <= entryAddr;
      if (ctl.stepEntry) fetchAddr <= fetchAddr + ADDR_W'(ENTRY_BYTES);
      if (ctl.takeSeg) begin
        segAddr  <= entryAddr;
        segLen   <= fLen;
        segLastR <= fLast;
        sumR     <= newSum;
      end
      if (ctl.setErr) errCode <= ctl.errVal;
    end
  end

  // the committed total never passes the requested count
  p_sum_bound_r8: assert property (@(posedge clk) disable iff (!rstN)
    sumR <= SUM_W'(totalR));

  // a committed descriptor never carries a zero length
  p_seg_len_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(segLastR) |-> segLen != '0);
endmodule

// File: rtl/sgControl.sv
module sgControl
  import sgPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  logic     memReqReady,
  input  logic     memRspValid,
  input  logic     segReady,
  input  dpFlags_t flags,
  output dpCtl_t   ctl,
  output logic     memReqValid,
  output logic     segValid,
  output logic     busy,
  output logic     done
);
  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_WAIT, S_EMIT, S_DONE} state_t;

  state_t state, stateNext;

  always_comb begin
    ctl       = '0;
    stateNext = state;
    unique case (state)
      S_IDLE, S_DONE: begin
        if (start) begin
          ctl.loadStart = 1'b1;
          stateNext     = S_FETCH;
        end
      end
      S_FETCH: begin
        if (memReqReady) stateNext = S_WAIT;
      end
      S_WAIT: begin
        if (memRspValid) begin
          if (flags.isNext) begin
            if (!flags.lenZero) begin
              ctl.setErr = 1'b1;
              ctl.errVal = ERR_NEXTLEN;
              stateNext  = S_DONE;
            end else begin
              ctl.jumpTable = 1'b1;
              stateNext     = S_FETCH;
            end
          end else if (flags.lenZero) begin
            ctl.setErr = 1'b1;
            ctl.errVal = ERR_ZEROLEN;
            stateNext  = S_DONE;
          end else if (flags.overRun || (flags.isLast && !flags.exactSum)) begin
            ctl.setErr = 1'b1;
            ctl.errVal = ERR_MISMATCH;
            stateNext  = S_DONE;
          end else begin
            ctl.takeSeg = 1'b1;
            stateNext   = S_EMIT;
          end
        end
      end
      S_EMIT: begin
        if (segReady) begin
          if (flags.segLast) begin
            stateNext = S_DONE;
          end else begin
            ctl.stepEntry = 1'b1;
            stateNext     = S_FETCH;
          end
        end
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  assign memReqValid = (state == S_FETCH);
  assign segValid    = (state == S_EMIT);
  assign done        = (state == S_DONE);
  assign busy        = (state == S_FETCH) || (state == S_WAIT) || (state == S_EMIT);

  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid);

  p_seg_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    segValid && !segReady |=> segValid);

  p_quiet_after_done_r9: assert property (@(posedge clk) disable iff (!rstN)
    done && !start |=> done && !memReqValid);

  p_busy_start_r12: assert property (@(posedge clk) disable iff (!rstN)
    busy && start && !(segValid && segReady) && !memRspValid |=> busy);

  p_excl_r1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({memReqValid, segValid, done}));
endmodule

// File: rtl/sgWalker.sv
module sgWalker
  import sgPkg::*;
#(
  parameter int TOTAL_W = 20
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [35:0]        startAddr,
  input  logic [TOTAL_W-1:0] startTotal,
  input  logic               extEn,
  output logic               memReqValid,
  input  logic               memReqReady,
  output logic [35:0]        memReqAddr,
  input  logic               memRspValid,
  input  logic [63:0]        memRspData,
  output logic               segValid,
  input  logic               segReady,
  output logic [35:0]        segAddr,
  output logic [15:0]        segLen,
  output logic               busy,
  output logic               done,
  output logic               errFlag,
  output logic [1:0]         errCode
);
  dpCtl_t   ctl;
  dpFlags_t flags;
  errCode_t errState;

  sgControl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .start       (start),
    .memReqReady (memReqReady),
    .memRspValid (memRspValid),
    .segReady    (segReady),
    .flags       (flags),
    .ctl         (ctl),
    .memReqValid (memReqValid),
    .segValid    (segValid),
    .busy        (busy),
    .done        (done)
  );

  sgDatapath #(.TOTAL_W(TOTAL_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .startAddr  (startAddr),
    .startTotal (startTotal),
    .extEn      (extEn),
    .rspData    (memRspData),
    .fetchAddr  (memReqAddr),
    .segAddr    (segAddr),
    .segLen     (segLen),
    .errCode    (errState),
    .flags      (flags)
  );

  assign errCode = errState;
  assign errFlag = (errState != ERR_NONE);

  p_addr_stable_r11: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> $stable(memReqAddr));

  p_seg_stable_r10: assert property (@(posedge clk) disable iff (!rstN)
    segValid && !segReady |=> $stable(segAddr) && $stable(segLen));

  p_err_done_r9: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> done);

  p_seg_nonzero_r6: assert property (@(posedge clk) disable iff (!rstN)
    segValid |-> segLen != 16'd0);
endmodule

// File: tb/sgWalker_test.sv
module sgWalker_test;
  localparam int TW = 20;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [35:0]   startAddr = '0;
  logic [TW-1:0] startTotal = '0;
  logic          extEn = 1'b0;
  logic          memReqValid;
  logic          memReqReady = 1'b0;
  logic [35:0]   memReqAddr;
  logic          memRspValid = 1'b0;
  logic [63:0]   memRspData = '0;
  logic          segValid;
  logic          segReady = 1'b0;
  logic [35:0]   segAddr;
  logic [15:0]   segLen;
  logic          busy, done, errFlag;
  logic [1:0]    errCode;

  always #5 clk = ~clk;

  sgWalker #(.TOTAL_W(TW)) uut (
    .clk(clk), .rstN(rstN), .start(start), .startAddr(startAddr),
    .startTotal(startTotal), .extEn(extEn),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspData(memRspData),
    .segValid(segValid), .segReady(segReady), .segAddr(segAddr), .segLen(segLen),
    .busy(busy), .done(done), .errFlag(errFlag), .errCode(errCode)
  );

  int nVec = 0;
  int nFail = 0;
  int cyc = 0;
  int bpMode = 0;

  logic [63:0] memArr [0:255];
  logic        rspPend = 1'b0;
  logic [7:0]  rspIdx = '0;

  logic [35:0] fetchLog [$];
  logic [35:0] segALog [$];
  logic [15:0] segLLog [$];

  logic [35:0] entAddr [$];
  logic [63:0] entData [$];

  // memory model and descriptor sink, all on the falling edge
  always @(negedge clk) begin
    cyc++;
    if (rspPend) begin
      memRspValid = 1'b1;
      memRspData  = memArr[rspIdx];
      rspPend     = 1'b0;
    end else begin
      memRspValid = 1'b0;
    end
    memReqReady = (bpMode == 0) ? 1'b1 : ((cyc % 3) != 0);
    if (memReqValid && memReqReady) begin
      fetchLog.push_back(memReqAddr);
      rspPend = 1'b1;
      rspIdx  = memReqAddr[10:3];
    end
    segReady = (bpMode == 0) ? 1'b1 : ((cyc % 4) == 1);
    if (segValid && segReady) begin
      segALog.push_back(segAddr);
      segLLog.push_back(segLen);
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nVec++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] mkEntry(input logic [15:0] len, input logic last,
      input logic nxt, input logic [3:0] ext, input logic [31:0] ptr);
    return {len, 6'b0, last, nxt, 4'b0, ext, ptr};
  endfunction

  function automatic string errReq(input int e);
    case (e)
      0: return "R7";
      1: return "R6";
      2: return "R8";
      default: return "R5";
    endcase
  endfunction

  // run the list in entAddr/entData, predict the outcome and compare
  task automatic runList(input logic [TW-1:0] total, input logic xe,
                         input int bp, input logic poke);
    logic [35:0] expF [$];
    logic [35:0] expA [$];
    logic [15:0] expL [$];
    int expErr = 0;
    int sum = 0;
    int fcnt;
    bit seenDone = 0;
    foreach (entAddr[i]) memArr[entAddr[i][10:3]] = entData[i];
    for (int i = 0; i < entAddr.size(); i++) begin
      logic [63:0] d = entData[i];
      expF.push_back(entAddr[i]);
      if (d[40]) begin
        if (d[63:48] != 16'd0) begin expErr = 3; break; end
        continue;
      end
      if (d[63:48] == 16'd0) begin expErr = 1; break; end
      sum += int'(d[63:48]);
      if (sum > int'(total) || (d[41] && sum != int'(total))) begin expErr = 2; break; end
      expA.push_back({(xe ? d[35:32] : 4'h0), d[31:0]});
      expL.push_back(d[63:48]);
      if (d[41]) break;
    end
    fetchLog.delete(); segALog.delete(); segLLog.delete();
    @(negedge clk);
    bpMode = bp; extEn = xe; startTotal = total;
    startAddr = entAddr[0]; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      @(negedge clk); @(negedge clk);
      chk("R12", "busy before poke", {63'd0, busy}, 64'd1);
      startAddr = 36'h0_0000_0700; startTotal = 1; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    for (int k = 0; k < 3000; k++) begin
      if (done) begin seenDone = 1; break; end
      @(negedge clk);
    end
    if (!seenDone) begin
      nFail++;
      $display("FAIL R7 watchdog actual=not-done expected=done");
    end
    chk("R11", "read count", 64'(fetchLog.size()), 64'(expF.size()));
    for (int i = 0; i < expF.size() && i < fetchLog.size(); i++)
      chk((i > 0 && expF[i][2:0] == 3'd0 && expF[i] != expF[i-1] + 36'd8) ? "R4" : "R1",
          "read addr", 64'(fetchLog[i]), 64'(expF[i]));
    chk(bp != 0 ? "R10" : "R2", "descriptor count", 64'(segALog.size()), 64'(expA.size()));
    for (int i = 0; i < expA.size() && i < segALog.size(); i++) begin
      chk(xe ? "R3" : "R2", "desc addr", 64'(segALog[i]), 64'(expA[i]));
      chk("R2", "desc len", 64'(segLLog[i]), 64'(expL[i]));
    end
    chk(errReq(expErr), "error code", 64'(errCode), 64'(expErr));
    chk(errReq(expErr), "error flag", {63'd0, errFlag}, {63'd0, expErr != 0});
    fcnt = fetchLog.size();
    repeat (6) @(negedge clk);
    chk("R9", "reads after end", 64'(fetchLog.size()), 64'(fcnt));
    chk("R9", "done held", {63'd0, done}, 64'd1);
    chk("R9", "code held", 64'(errCode), 64'(expErr));
  endtask

  task automatic buildSweep(input int nT, input int nPer, input logic xe,
                            output int sumAll, output int lastLen);
    entAddr.delete(); entData.delete();
    sumAll = 0; lastLen = 0;
    for (int t = 0; t < nT; t++) begin
      logic [31:0] base = 32'((t + 1) * 256);
      logic [35:0] tAddr = (t == 0) ? {4'h0, base} : {(xe ? 4'h3 : 4'h0), base};
      for (int e = 0; e < nPer; e++) begin
        int len = 1 + ((t * 5 + e * 11 + nPer * 3) % 40);
        logic lastE = (t == nT - 1) && (e == nPer - 1);
        entAddr.push_back(tAddr + 36'(8 * e));
        entData.push_back(mkEntry(16'(len), lastE, 1'b0, 4'(8 + t),
                                  32'h0040_0000 + 32'(t * 4096) + 32'(e * 64)));
        sumAll += len;
        if (lastE) lastLen = len;
      end
      if (t < nT - 1) begin
        entAddr.push_back(tAddr + 36'(8 * nPer));
        entData.push_back(mkEntry(16'd0, 1'b1, 1'b1, 4'h3, 32'((t + 2) * 256)));
      end
    end
  endtask

  initial begin
    #2_000_000;
    nFail++;
    $display("FAIL R7 global watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
    $finish;
  end

  initial begin
    int s, ll, tot;
    for (int i = 0; i < 256; i++) memArr[i] = '0;
    repeat (3) @(negedge clk);
    chk("R13", "busy", {63'd0, busy}, 64'd0);
    chk("R13", "done", {63'd0, done}, 64'd0);
    chk("R13", "errFlag", {63'd0, errFlag}, 64'd0);
    chk("R13", "memReqValid", {63'd0, memReqValid}, 64'd0);
    chk("R13", "segValid", {63'd0, segValid}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);

    for (int nT = 1; nT <= 3; nT++)
      for (int nPer = 1; nPer <= 3; nPer++)
        for (int xe = 0; xe <= 1; xe++)
          for (int v = 0; v < 4; v++)
            for (int bp = 0; bp <= 1; bp++) begin
              buildSweep(nT, nPer, xe[0], s, ll);
              case (v)
                0: tot = s;
                1: tot = s + 1;
                2: tot = s - 1;
                default: tot = (s - ll > 0) ? s - ll - 1 : 0;
              endcase
              runList(TW'(tot), xe[0], bp, 1'b0);
            end

    // R6: zero-length ordinary entry after a good one
    entAddr.delete(); entData.delete();
    entAddr.push_back(36'h0_0000_0100); entData.push_back(mkEntry(16'd10, 1'b0, 1'b0, 4'h1, 32'h0000_5000));
    entAddr.push_back(36'h0_0000_0108); entData.push_back(mkEntry(16'd0, 1'b1, 1'b0, 4'h1, 32'h0000_6000));
    runList(TW'(10), 1'b1, 0, 1'b0);

    // R5: continuation carrying a length
    entAddr.delete(); entData.delete();
    entAddr.push_back(36'h0_0000_0100); entData.push_back(mkEntry(16'd4, 1'b0, 1'b1, 4'h2, 32'h0000_0200));
    runList(TW'(4), 1'b0, 1, 1'b0);

    // R12: start pulse mid-walk is ignored
    buildSweep(3, 3, 1'b1, s, ll);
    runList(TW'(s), 1'b1, 1, 1'b1);

    // R7: exact single entry, largest length
    entAddr.delete(); entData.delete();
    entAddr.push_back(36'h0_0000_0300); entData.push_back(mkEntry(16'hFFFF, 1'b1, 1'b0, 4'hF, 32'hFFFF_FFF8));
    runList(TW'(65535), 1'b1, 1, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
    $finish;
  end
endmodule